// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers the interrupt request lines of the peripherals on a chip and presents one winner to a processor core: the interrupt level of the most urgent pending request (1 to 7) and the vector number that belongs to it. Every source has a fixed level and a priority inside that level. Two sources are hard-wired to level 7, which cannot be masked. A third output tells the core when the winner beats the core's current interrupt mask.

Software reaches three byte-wide registers. The force register injects a software request at any level. Each of the two promotion registers can lift one chosen peripheral to the top of level 6, above every other maskable request. Promotion changes the level and the priority of the source but not its vector. Arbitration is evaluated in full every clock and the result is registered once.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous reset, all three registers read 0, and `irq_level`, `irq_vector` and `irq_valid` are 0. Reading address 3 returns 0.
- R2: The force register is at address 0. Write-data bit k, for k from 0 to 6, holds a software request at level 7-k: a 1 asserts it and a 0 removes it. A software request at level n reports vector 120+n.
- R3: Bit 7 of the force register is reserved. Writes to it are dropped, and it always reads 0.
- R4: Source 0 never requests. Sources 1 and 2 are fixed at level 7, priority 7. Any other source i has level 1+(i mod 6) and priority (i div 6) mod 6, unless it is promoted.
- R5: The winner is chosen by higher level first, then higher priority. At equal level, a peripheral beats a software request. Between peripherals of equal level and priority, the lower index wins.
- R6: The promotion register at address 1 holds a source index in its low clog2(NUM_SRC) bits, and the upper bits read 0. The named source is treated as level 6, priority 7. A value of 0, a value that names source 1 or 2, or a value of NUM_SRC or more has no effect.
- R7: The promotion register at address 2 works the same way, with level 6 and priority 6. If both promotion registers name the same source, the priority-7 promotion applies.
- R8: A pending peripheral i always reports vector 64+i, whether or not it is promoted.
- R9: `irq_valid` is 1 when the winning level is 7, or when the winning level is greater than `core_mask`.
- R10: A change on `src_req` or `core_mask` appears on the outputs after exactly one rising edge. A register write appears one edge after the edge that stores it.
- R11: When nothing is pending, `irq_level` and `irq_vector` are 0 and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Peripheral request lines, one per source index |
| core_mask | input | 3 | Current interrupt mask level of the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 force, 1 priority-7 promotion, 2 priority-6 promotion |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| irq_valid | output | 1 | Winner is level 7 or is above `core_mask` |
| irq_level | output | 3 | Level of the winning request, 0 when nothing is pending |
| irq_vector | output | 8 | Vector of the winning request, 0 when nothing is pending |

## Verification
The bench builds the block with NUM_SRC = 12, so the promotion field is 4 bits wide. This small build makes several sweeps exhaustive: every single source under every mask value, every pair of sources, every force byte, and every pair of promotion values including the out-of-range indices 12 to 15. Twelve sources cover all six default levels, two priority values inside a level, and the two level-7 sources. Ties on level and priority, collisions between software and peripheral requests, and promotion of a hard-wired source can therefore all be reached in a few thousand cycles. A long pseudo-random run then mixes all inputs against an arithmetic model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL        = 7;
  localparam int LVL_W          = 3;
  localparam int PRI_W          = 3;
  localparam int VEC_W          = 8;
  localparam int SRC_VEC_BASE   = 64;
  localparam int FORCE_VEC_BASE = 120;
  localparam int HARD_A         = 1;
  localparam int HARD_B         = 2;
  localparam int PROMO_LVL      = 6;

  localparam logic [1:0] ADDR_FORCE    = 2'd0;
  localparam logic [1:0] ADDR_PROMO_HI = 2'd1;
  localparam logic [1:0] ADDR_PROMO_LO = 2'd2;

  function automatic logic [LVL_W-1:0] dflt_level(input int idx);
    return LVL_W'(1 + (idx % 6));
  endfunction

  function automatic logic [PRI_W-1:0] dflt_prio(input int idx);
    return PRI_W'((idx / 6) % 6);
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [NUM_LVL:1] force_lvl,
  output logic [SRC_W-1:0] promo_hi,
  output logic [SRC_W-1:0] promo_lo
);
  logic [NUM_LVL-1:0] force_q;
  logic               unused_rsv;

  assign unused_rsv = wdata[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q  <= '0;
      promo_hi <= '0;
      promo_lo <= '0;
    end else if (we) begin
      case (addr)
        ADDR_FORCE:    force_q  <= wdata[NUM_LVL-1:0];
        ADDR_PROMO_HI: promo_hi <= wdata[SRC_W-1:0];
        ADDR_PROMO_LO: promo_lo <= wdata[SRC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_FORCE:    rdata = 8'(force_q);
      ADDR_PROMO_HI: rdata = 8'(promo_hi);
      ADDR_PROMO_LO: rdata = 8'(promo_lo);
      default:       rdata = 8'd0;
    endcase
  end

  // bit k of the stored byte requests level NUM_LVL-k
  for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_force_map
    assign force_lvl[lv] = force_q[NUM_LVL-lv];
  end
endmodule

// File: rtl/irq_rank.sv
module irq_rank
  import irq_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SRC_W = 6,
  parameter int KEY_W = LVL_W + PRI_W + 1 + SRC_W
) (
  input  logic             req,
  input  logic [SRC_W-1:0] promo_hi,
  input  logic [SRC_W-1:0] promo_lo,
  output logic [KEY_W-1:0] key,
  output logic [VEC_W-1:0] vec
);
  localparam bit               HARD  = (IDX == HARD_A) || (IDX == HARD_B);
  localparam bit               LIVE  = (IDX != 0);
  localparam logic [SRC_W-1:0] MY_ID = SRC_W'(IDX);

  logic [LVL_W-1:0] lvl;
  logic [PRI_W-1:0] pri;

  always_comb begin
    lvl = dflt_level(IDX);
    pri = dflt_prio(IDX);
    if (HARD) begin
      lvl = LVL_W'(NUM_LVL);
      pri = '1;
    end else if (promo_hi == MY_ID) begin
      lvl = LVL_W'(PROMO_LVL);
      pri = PRI_W'(7);
    end else if (promo_lo == MY_ID) begin
      lvl = LVL_W'(PROMO_LVL);
      pri = PRI_W'(6);
    end
  end

  // key = {level, priority, peripheral flag, inverted index}: max wins
  assign key = (req && LIVE) ? {lvl, pri, 1'b1, ~MY_ID} : '0;
  assign vec = VEC_W'(SRC_VEC_BASE + IDX);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N     = 63,
  parameter int KEY_W = 13
) (
  input  logic [N-1:0][KEY_W-1:0] keys,
  input  logic [N-1:0][VEC_W-1:0] vecs,
  output logic [KEY_W-1:0]        best_key,
  output logic [VEC_W-1:0]        best_vec
);
  always_comb begin
    best_key = '0;
    best_vec = '0;
    for (int e = 0; e < N; e++) begin
      if (keys[e] > best_key) begin
        best_key = keys[e];
        best_vec = vecs[e];
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [2:0]         core_mask,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_valid,
  output logic [2:0]         irq_level,
  output logic [7:0]         irq_vector
);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int KEY_W   = LVL_W + PRI_W + 1 + SRC_W;
  localparam int NUM_ENT = NUM_SRC + NUM_LVL;

  logic [NUM_LVL:1]               force_lvl;
  logic [SRC_W-1:0]               promo_hi, promo_lo;
  logic [NUM_ENT-1:0][KEY_W-1:0]  keys;
  logic [NUM_ENT-1:0][VEC_W-1:0]  vecs;
  logic [KEY_W-1:0]               best_key;
  logic [VEC_W-1:0]               best_vec;
  logic [LVL_W-1:0]               win_lvl;
  logic                           unused_key;

  irq_regs #(.SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .force_lvl(force_lvl), .promo_hi(promo_hi), .promo_lo(promo_lo)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irq_rank #(.IDX(s), .SRC_W(SRC_W), .KEY_W(KEY_W)) u_rank (
      .req(src_req[s]), .promo_hi(promo_hi), .promo_lo(promo_lo),
      .key(keys[s]), .vec(vecs[s])
    );
  end

  // software requests: priority 0 and flag 0, below any peripheral of the same level
  for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_force
    assign keys[NUM_SRC+lv-1] = force_lvl[lv] ?
      {LVL_W'(lv), PRI_W'(0), 1'b0, SRC_W'(0)} : '0;
    assign vecs[NUM_SRC+lv-1] = VEC_W'(FORCE_VEC_BASE + lv);
  end

  irq_arbiter #(.N(NUM_ENT), .KEY_W(KEY_W)) u_arb (
    .keys(keys), .vecs(vecs), .best_key(best_key), .best_vec(best_vec)
  );

  assign win_lvl    = best_key[KEY_W-1 -: LVL_W];
  assign unused_key = ^best_key[KEY_W-LVL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_level  <= win_lvl;
      irq_vector <= (win_lvl != 0) ? best_vec : '0;
      irq_valid  <= (win_lvl != 0) &&
                    ((win_lvl == LVL_W'(NUM_LVL)) || (win_lvl > core_mask));
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int NUM_SRC = 56
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] core_mask,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       irq_valid,
  input logic [2:0] irq_level,
  input logic [7:0] irq_vector
);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_level == 3'd0) |-> (!irq_valid && irq_vector == 8'd0));

  p_nmi_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_level == 3'd7) |-> irq_valid);

  p_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_level != 3'd7) |-> (irq_level > $past(core_mask)));

  p_src_vec_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_level != 3'd0 && irq_vector < 8'd121) |->
      (irq_vector >= 8'd64 && irq_vector < 8'(64 + NUM_SRC)));

  p_force_vec_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_vector >= 8'd121) |-> (irq_vector == 8'd120 + {5'd0, irq_level}));

  p_rsv_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0) |-> (reg_rdata[7] == 1'b0));

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_level == 3'd0 && !irq_valid));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .core_mask(core_mask), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level),
  .irq_vector(irq_vector)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_req = '0;
  logic [2:0]    core_mask = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_valid;
  logic [2:0]    irq_level;
  logic [7:0]    irq_vector;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [6:0] sh_force = '0;
  logic [3:0] sh_hi = '0, sh_lo = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_level_ctrl #(.NUM_SRC(NS)) u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .core_mask(core_mask),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_vector(irq_vector)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic void model(output int el, output int ev, output bit eok);
    int bl = 0, bp = -2, bv = 0, l, p;
    for (int n = 1; n <= 7; n++)
      if (sh_force[7-n] && n > bl) begin bl = n; bp = -1; bv = 120 + n; end
    for (int i = 1; i < NS; i++) begin
      if (src_req[i]) begin
        if (i <= 2) begin l = 7; p = 7; end
        else if (int'(sh_hi) == i) begin l = 6; p = 7; end
        else if (int'(sh_lo) == i) begin l = 6; p = 6; end
        else begin l = 1 + i % 6; p = (i / 6) % 6; end
        if (l > bl || (l == bl && p > bp)) begin bl = l; bp = p; bv = 64 + i; end
      end
    end
    el  = bl;
    ev  = (bl != 0) ? bv : 0;
    eok = (bl != 0) && (bl == 7 || bl > int'(core_mask));
  endfunction

  task automatic cmp(input string rq);
    int el, ev; bit eok;
    model(el, ev, eok);
    n_vec++;
    if (int'(irq_level) != el || int'(irq_vector) != ev || irq_valid != eok) begin
      n_bad++;
      $display("FAIL %s: got lvl=%0d vec=%0d valid=%0d expected lvl=%0d vec=%0d valid=%0d",
               rq, irq_level, irq_vector, irq_valid, el, ev, eok);
    end
  endtask

  task automatic cmp_rd(input logic [1:0] a, input logic [7:0] exp, input string rq);
    reg_addr = a;
    #1;
    n_vec++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %0h expected %0h", rq, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) sh_force = d[6:0];
    if (a == 2'd1) sh_hi = d[3:0];
    if (a == 2'd2) sh_lo = d[3:0];
  endtask

  task automatic step(input logic [NS-1:0] r, input logic [2:0] m, input string rq);
    src_req = r; core_mask = m;
    @(negedge clk);
    cmp(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of registers and outputs
    cmp("R1");
    for (int a = 0; a < 4; a++) cmp_rd(2'(a), 8'h00, "R1");

    // R4 R9 R10 R11: every single source under every mask, one-edge latency
    for (int i = 0; i < NS; i++)
      for (int m = 0; m < 8; m++) begin
        step(NS'(1) << i, 3'(m), "R4");
        step('0, 3'(m), "R11");
      end

    // R5: every pair of sources
    for (int i = 0; i < NS; i++)
      for (int j = i + 1; j < NS; j++)
        step((NS'(1) << i) | (NS'(1) << j), 3'd0, "R5");

    // R10: register write takes effect one edge after it is stored
    src_req = '0;
    wr(2'd0, 8'h01);
    n_vec++;
    if (irq_level != 3'd0) begin
      n_bad++;
      $display("FAIL R10: early level got %0d expected 0", irq_level);
    end
    @(negedge clk);
    cmp("R10");

    // R2 R3: every force byte, alone and against a peripheral at level 6
    for (int w = 0; w < 256; w++) begin
      wr(2'd0, 8'(w));
      cmp_rd(2'd0, 8'(w) & 8'h7f, "R3");
      @(negedge clk);
      cmp("R2");
      step(NS'(1) << 5, 3'd2, "R5");
      src_req = '0;
    end
    wr(2'd0, 8'h00);

    // R6 R7 R8: every pair of promotion values, upper bits set to show they drop
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        wr(2'd1, {4'b1010, 4'(a)});
        wr(2'd2, {4'b0101, 4'(b)});
        cmp_rd(2'd1, 8'(a), "R6");
        cmp_rd(2'd2, 8'(b), "R7");
        step(~NS'(6), 3'd3, "R6");
        step(NS'(1) << b, 3'd5, "R7");
        step(NS'(1) << a | NS'(1) << 10, 3'd0, "R8");
      end

    // mixed pseudo-random run over all inputs
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] r;
      r = rnd();
      if (r[3:0] == 4'd0) wr(2'd0, rnd() [7:0] & 8'h9f);
      if (r[7:4] == 4'd1) wr(2'd1, rnd() [7:0]);
      if (r[7:4] == 4'd2) wr(2'd2, rnd() [7:0]);
      step(NS'(rnd()) & NS'(rnd()), r[10:8], "R5");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule